// File: doc/BRIEF.md
# NiMH Charge Cycle Sequencer

This block steps a series nickel-metal-hydride pack through a complete charge cycle. It takes digitized status flags from the analog front end and decides which charge phase is active. The flags are supply health, three cell-voltage comparisons (below 1.0 V, below 1.55 V, above 1.65 V), two temperature windows (inside 0 to 45 °C, above 50 °C), a temperature-slope termination flag and a discharge-latch flag. It drives a charge-regulation enable, a current-level select for the regulator reference, a pass-element drive for discharge and a low-power indication. The current phase is exported as a 3-bit code that an LED pattern generator decodes.

All time limits are counted in one-second ticks produced from the clock by a prescaler. The fast-charge limit is a run-time input given in ticks, between 30 minutes and 6 hours in a real system. The top-off limit is that value shifted right by one. The pre-charge limit and the qualification filter are parameters. The supply-valid input passes through a deglitch filter of `DEGLITCH_CYC` clocks, and the filtered supply gates everything else. A pack-removal check (cell above 1.65 V) runs in every phase that holds a pack. All status pins are plain level signals; there is no streaming interface.

Top module: `nimh_charge_seq`

## Requirements
- R1: While `rst_n` is low, the state code is 0 (idle/reset), `chg_en`, `ilevel_hi` and `dchg_drive` are 0, and `low_power` is 1. State codes: 0 reset, 1 presence, 2 pre-charge, 3 fast, 4 top-off, 5 done, 6 fault, 7 discharge.
- R2: The filtered supply changes only after `supply_ok` has differed from it on `DEGLITCH_CYC` consecutive clocks. A filtered-low supply moves any state to 0 on the next clock, and this clears the timers. A filtered-high supply moves state 0 to state 1 on the next clock.
- R3: State 1 moves to state 2 once `v_lt_det`, `temp_ok` and not `v_gt_open` have held together for `QUAL_TICKS*CLK_PER_TICK` consecutive clocks. Any break in that condition restarts the count.
- R4: In state 2, `chg_en`=1 and `ilevel_hi`=0. The block moves to state 3 on the first clock where `v_lt_lb` is 0.
- R5: State 2 moves to state 6 when `temp_hot` is 1, or when `PRE_TICKS` ticks have elapsed in the state.
- R6: In state 3, `chg_en`=1 and `ilevel_hi`=1. The block moves to state 4 on `slope_term`, or when `fast_limit` ticks have elapsed. A limit of 0 expires at the first tick.
- R7: On entry to state 4 the timer restarts, and `ilevel_hi`=0 while `chg_en`=1. The block moves to state 5 after `fast_limit>>1` ticks.
- R8: `temp_hot` in state 3 or 4 moves the block to state 5.
- R9: `v_gt_open` in states 2, 3, 4, 5 or 6 moves the block to state 1 on the next clock.
- R10: `dchg_latch` in any state except 0 moves the block to state 7. There `dchg_drive`=1, `low_power`=1 and `chg_en`=0, and all voltage and temperature flags are ignored. When the latch clears, the block moves to state 1.
- R11: Priority, highest first: filtered supply, discharge latch, pack removal, over-temperature, phase progress (voltage reached or slope), timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above lockout threshold (raw) |
| v_lt_lb | input | 1 | Cell voltage below 1.0 V |
| v_lt_det | input | 1 | Cell voltage below 1.55 V |
| v_gt_open | input | 1 | Cell voltage above 1.65 V (pack absent) |
| temp_ok | input | 1 | Temperature inside 0 to 45 °C |
| temp_hot | input | 1 | Temperature above 50 °C |
| slope_term | input | 1 | Temperature slope termination flag |
| dchg_latch | input | 1 | Discharge latch set |
| fast_limit | input | SEC_W | Fast-charge limit in ticks |
| state_code | output | 3 | Current phase code |
| chg_en | output | 1 | Charge regulation enable |
| ilevel_hi | output | 1 | High current reference select |
| dchg_drive | output | 1 | Drive pass element on for discharge |
| low_power | output | 1 | Low-power indication |

## Verification
A wrong internal state shows at once, because every output is a decode of the state register. A bad transition therefore changes `state_code` and the drive pins on the clock it happens. A timer fault shows only later: a prescaler or tick counter that is off by one moves a phase exit by whole ticks or by single clocks. The reference model compares the exit clock exactly. Priority errors between removal, over-temperature and discharge show only when those flags change on the same clock, so the stimulus raises them together.

// File: rtl/nimh_pkg.sv
package nimh_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_PRESENT = 3'd1,
    ST_PRECHG  = 3'd2,
    ST_FAST    = 3'd3,
    ST_TOPOFF  = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6,
    ST_DRAIN   = 3'd7
  } chg_state_e;

  // States in which a pack is expected to sit in the charger
  function automatic logic holds_pack(chg_state_e s);
    return (s == ST_PRECHG) || (s == ST_FAST) || (s == ST_TOPOFF) ||
           (s == ST_DONE) || (s == ST_FAULT);
  endfunction
endpackage

// File: rtl/nimh_supply_filter.sv
module nimh_supply_filter #(
  parameter int DEGLITCH_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic supply_good
);
  generate
    if (DEGLITCH_CYC == 0) begin : g_direct
      assign supply_good = supply_ok;
    end else begin : g_filter
      localparam int CW = $clog2(DEGLITCH_CYC + 1);
      logic [CW-1:0] run_q;
      logic          good_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q  <= '0;
          good_q <= 1'b0;
        end else if (supply_ok == good_q) begin
          run_q <= '0;
        end else if (run_q == CW'(DEGLITCH_CYC - 1)) begin
          run_q  <= '0;
          good_q <= supply_ok;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
      assign supply_good = good_q;
    end
  endgenerate
endmodule

// File: rtl/nimh_tick_timer.sv
module nimh_tick_timer #(
  parameter int CLK_PER_TICK = 50000000,
  parameter int SEC_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic             tick,
  output logic [SEC_W-1:0] secs
);
  localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  logic [PW-1:0]    presc_q;
  logic [SEC_W-1:0] secs_q;

  assign tick = (presc_q == PW'(CLK_PER_TICK - 1));
  assign secs = secs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      secs_q  <= '0;
    end else if (clear) begin
      presc_q <= '0;
      secs_q  <= '0;
    end else if (tick) begin
      presc_q <= '0;
      secs_q  <= secs_q + 1'b1;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end
endmodule

// File: rtl/nimh_seq_fsm.sv
module nimh_seq_fsm
  import nimh_pkg::*;
#(
  parameter int SEC_W      = 16,
  parameter int QUAL_TICKS = 4,
  parameter int PRE_TICKS  = 1800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_good,
  input  logic             v_lt_lb,
  input  logic             v_lt_det,
  input  logic             v_gt_open,
  input  logic             temp_ok,
  input  logic             temp_hot,
  input  logic             slope_term,
  input  logic             dchg_latch,
  input  logic [SEC_W-1:0] fast_limit,
  input  logic             tick,
  input  logic [SEC_W-1:0] secs,
  output chg_state_e       state,
  output logic             timer_clear
);
  localparam int LW = SEC_W + 1;

  chg_state_e      state_q, nxt;
  logic            qual;
  logic [LW-1:0]   elapsed;

  // tick count including the tick happening this clock
  assign elapsed = {1'b0, secs} + LW'(1);
  assign qual    = v_lt_det && temp_ok && !v_gt_open;

  function automatic logic reached(input logic t, input logic [LW-1:0] el,
                                   input logic [LW-1:0] lim);
    return t && (el >= lim);
  endfunction

  always_comb begin
    nxt = state_q;
    if (!supply_good) begin
      nxt = ST_RESET;
    end else if (state_q != ST_RESET && dchg_latch) begin
      nxt = ST_DRAIN;
    end else if (holds_pack(state_q) && v_gt_open) begin
      nxt = ST_PRESENT;
    end else begin
      unique case (state_q)
        ST_RESET:   nxt = ST_PRESENT;
        ST_PRESENT: if (qual && reached(tick, elapsed, LW'(QUAL_TICKS))) nxt = ST_PRECHG;
        ST_PRECHG: begin
          if (temp_hot)                                    nxt = ST_FAULT;
          else if (!v_lt_lb)                               nxt = ST_FAST;
          else if (reached(tick, elapsed, LW'(PRE_TICKS))) nxt = ST_FAULT;
        end
        ST_FAST: begin
          if (temp_hot)                                    nxt = ST_DONE;
          else if (slope_term ||
                   reached(tick, elapsed, {1'b0, fast_limit})) nxt = ST_TOPOFF;
        end
        ST_TOPOFF: begin
          if (temp_hot)                                    nxt = ST_DONE;
          else if (reached(tick, elapsed, {2'b00, fast_limit[SEC_W-1:1]})) nxt = ST_DONE;
        end
        ST_DONE, ST_FAULT: nxt = state_q;
        ST_DRAIN:   nxt = ST_PRESENT;
        default:    nxt = ST_RESET;
      endcase
    end
  end

  assign timer_clear = (nxt != state_q) || (state_q == ST_PRESENT && !qual);
  assign state       = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= nxt;
  end
endmodule

// File: rtl/nimh_charge_seq.sv
module nimh_charge_seq
  import nimh_pkg::*;
#(
  parameter int CLK_PER_TICK = 50000000,
  parameter int DEGLITCH_CYC = 500000,
  parameter int SEC_W        = 16,
  parameter int QUAL_TICKS   = 4,
  parameter int PRE_TICKS    = 1800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             v_lt_lb,
  input  logic             v_lt_det,
  input  logic             v_gt_open,
  input  logic             temp_ok,
  input  logic             temp_hot,
  input  logic             slope_term,
  input  logic             dchg_latch,
  input  logic [SEC_W-1:0] fast_limit,
  output logic [2:0]       state_code,
  output logic             chg_en,
  output logic             ilevel_hi,
  output logic             dchg_drive,
  output logic             low_power
);
  logic             supply_good;
  logic             tick, timer_clear;
  logic [SEC_W-1:0] secs;
  chg_state_e       state;

  nimh_supply_filter #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_good(supply_good)
  );

  nimh_tick_timer #(.CLK_PER_TICK(CLK_PER_TICK), .SEC_W(SEC_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear), .tick(tick), .secs(secs)
  );

  nimh_seq_fsm #(.SEC_W(SEC_W), .QUAL_TICKS(QUAL_TICKS), .PRE_TICKS(PRE_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
    .v_lt_lb(v_lt_lb), .v_lt_det(v_lt_det), .v_gt_open(v_gt_open),
    .temp_ok(temp_ok), .temp_hot(temp_hot), .slope_term(slope_term),
    .dchg_latch(dchg_latch), .fast_limit(fast_limit),
    .tick(tick), .secs(secs), .state(state), .timer_clear(timer_clear)
  );

  assign state_code = state;
  assign chg_en     = (state == ST_PRECHG) || (state == ST_FAST) || (state == ST_TOPOFF);
  assign ilevel_hi  = (state == ST_FAST);
  assign dchg_drive = (state == ST_DRAIN);
  assign low_power  = (state == ST_DRAIN) || (state == ST_RESET);
endmodule

// File: rtl/nimh_charge_seq_chk.sv
module nimh_charge_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       supply_good,
  input logic       v_gt_open,
  input logic       dchg_latch,
  input logic [2:0] state_code,
  input logic       chg_en
);
  // R2: filtered supply loss forces reset on the next clock
  assert_supply_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> state_code == 3'd0);

  // R10: discharge latch takes priority outside reset
  assert_drain_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dchg_latch && supply_good && supply_ok && state_code != 3'd0) |=> state_code == 3'd7);

  // R9: removal check in pack-holding states
  assert_removal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code >= 3'd2 && state_code <= 3'd6 && v_gt_open && !dchg_latch &&
     supply_good && supply_ok) |=> state_code == 3'd1);

  // R3: charging only ever starts from the presence state
  assert_charge_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_en) |-> $past(state_code) == 3'd1);

  // R5: fault is entered only from pre-charge
  assert_fault_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd6 && $past(state_code) != 3'd6) |-> $past(state_code) == 3'd2);

  // R8: done is entered only from fast or top-off
  assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5 && $past(state_code) != 3'd5) |->
    ($past(state_code) == 3'd3 || $past(state_code) == 3'd4));
endmodule

bind nimh_charge_seq nimh_charge_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_good(supply_good),
  .v_gt_open(v_gt_open), .dchg_latch(dchg_latch), .state_code(state_code),
  .chg_en(chg_en)
);

// File: tb/nimh_charge_seq_test.sv
module nimh_charge_seq_test;
  localparam int CPT  = 4;
  localparam int DG   = 3;
  localparam int SW   = 16;
  localparam int QUAL = 4;
  localparam int PRE  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 0, v_lt_lb = 0, v_lt_det = 0, v_gt_open = 1;
  logic temp_ok = 0, temp_hot = 0, slope_term = 0, dchg_latch = 0;
  logic [SW-1:0] fast_limit = 16'd10;
  logic [2:0] state_code;
  logic chg_en, ilevel_hi, dchg_drive, low_power;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  nimh_charge_seq #(.CLK_PER_TICK(CPT), .DEGLITCH_CYC(DG), .SEC_W(SW),
                    .QUAL_TICKS(QUAL), .PRE_TICKS(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .v_lt_lb(v_lt_lb),
    .v_lt_det(v_lt_det), .v_gt_open(v_gt_open), .temp_ok(temp_ok),
    .temp_hot(temp_hot), .slope_term(slope_term), .dchg_latch(dchg_latch),
    .fast_limit(fast_limit), .state_code(state_code), .chg_en(chg_en),
    .ilevel_hi(ilevel_hi), .dchg_drive(dchg_drive), .low_power(low_power));

  // ---------------- behavioural reference model ----------------
  int m_state = 0, m_cyc = 0, m_run = 0;
  bit m_good = 0;

  function automatic bit hit(int cyc, int lim);
    return ((cyc + 1) % CPT == 0) && ((cyc + 1) / CPT >= lim);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cyc = 0; m_run = 0; m_good = 0;
    end else begin
      int nx;
      bit q, good_now;
      good_now = m_good;
      q = v_lt_det && temp_ok && !v_gt_open;
      nx = m_state;
      if (!good_now) nx = 0;
      else if (m_state != 0 && dchg_latch) nx = 7;
      else if (m_state >= 2 && m_state <= 6 && v_gt_open) nx = 1;
      else begin
        case (m_state)
          0: nx = 1;
          1: if (q && hit(m_cyc, QUAL)) nx = 2;
          2: if (temp_hot) nx = 6; else if (!v_lt_lb) nx = 3; else if (hit(m_cyc, PRE)) nx = 6;
          3: if (temp_hot) nx = 5; else if (slope_term || hit(m_cyc, int'(fast_limit))) nx = 4;
          4: if (temp_hot) nx = 5; else if (hit(m_cyc, int'(fast_limit) / 2)) nx = 5;
          7: nx = 1;
          default: ;
        endcase
      end
      if (nx != m_state || (m_state == 1 && !q)) m_cyc = 0; else m_cyc++;
      m_state = nx;
      // supply filter
      if (supply_ok == m_good) m_run = 0;
      else begin
        m_run++;
        if (m_run == DG) begin m_good = supply_ok; m_run = 0; end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      check(int'(state_code) == m_state, cur_req, "state", state_code, m_state);
      check(chg_en == (m_state >= 2 && m_state <= 4), cur_req, "chg_en", chg_en,
            m_state >= 2 && m_state <= 4);
      check(ilevel_hi == (m_state == 3), cur_req, "ilevel_hi", ilevel_hi, m_state == 3);
      check(dchg_drive == (m_state == 7), cur_req, "dchg_drive", dchg_drive, m_state == 7);
      check(low_power == (m_state == 7 || m_state == 0), cur_req, "low_power", low_power,
            m_state == 7 || m_state == 0);
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(int code, int limit, string req);
    int n = 0;
    while (m_state != code && n < limit) begin @(negedge clk); n++; end
    check(int'(state_code) == code, req, "reached state", state_code, code);
  endtask

  task automatic insert_pack();
    v_gt_open = 0; v_lt_det = 1; temp_ok = 1; v_lt_lb = 1;
    wait_state(2, 40, "R3");
  endtask

  task automatic remove_pack();
    v_gt_open = 1; v_lt_det = 0;
    wait_state(1, 4, "R9");
  endtask

  initial begin
    cur_req = "R1";
    run(3);
    check(state_code == 3'd0 && low_power && !chg_en && !dchg_drive, "R1",
          "reset outputs", state_code, 0);
    rst_n = 1;
    // R2: short supply pulse is filtered
    cur_req = "R2";
    @(negedge clk); supply_ok = 1; run(2); supply_ok = 0; run(5);
    check(state_code == 3'd0, "R2", "glitch ignored", state_code, 0);
    supply_ok = 1;
    wait_state(1, 10, "R2");
    // R3: no pack, stay in presence
    cur_req = "R3";
    run(40);
    check(state_code == 3'd1, "R3", "no pack stays", state_code, 1);
    v_gt_open = 0; v_lt_det = 1; temp_ok = 1; v_lt_lb = 1;
    run(10); temp_ok = 0; run(1); temp_ok = 1; run(12);
    check(state_code == 3'd1, "R3", "qualify restarted", state_code, 1);
    wait_state(2, 20, "R3");
    cur_req = "R4";
    check(chg_en && !ilevel_hi, "R4", "precharge low level", ilevel_hi, 0);
    run(5); v_lt_lb = 0;
    wait_state(3, 4, "R4");
    cur_req = "R6";
    check(ilevel_hi == 1'b1, "R6", "fast high level", ilevel_hi, 1);
    run(8); slope_term = 1; run(1); slope_term = 0;
    wait_state(4, 4, "R6");
    cur_req = "R7";
    check(!ilevel_hi && chg_en, "R7", "topoff low level", ilevel_hi, 0);
    wait_state(5, 30, "R7");
    cur_req = "R9";
    run(10); remove_pack();
    // R5: precharge timeout
    cur_req = "R5";
    insert_pack();
    wait_state(6, 100, "R5");
    cur_req = "R9"; remove_pack();
    cur_req = "R5"; insert_pack(); run(3); temp_hot = 1;
    wait_state(6, 4, "R5"); temp_hot = 0;
    cur_req = "R9"; remove_pack();
    // R6 timeout, R8 overtemp
    cur_req = "R6"; insert_pack(); v_lt_lb = 0;
    wait_state(3, 4, "R6");
    wait_state(4, 60, "R6");
    cur_req = "R8"; run(3); temp_hot = 1;
    wait_state(5, 4, "R8"); temp_hot = 0;
    cur_req = "R9"; remove_pack();
    // R11: removal beats overtemp
    cur_req = "R11"; insert_pack(); v_lt_lb = 0; wait_state(3, 4, "R11");
    temp_hot = 1; v_gt_open = 1; v_lt_det = 0;
    run(1);
    check(state_code == 3'd1, "R11", "removal over hot", state_code, 1);
    temp_hot = 0;
    // R10: discharge
    cur_req = "R10"; insert_pack(); v_lt_lb = 0; wait_state(3, 4, "R10");
    dchg_latch = 1;
    wait_state(7, 3, "R10");
    check(dchg_drive && low_power && !chg_en, "R10", "drain outputs", dchg_drive, 1);
    v_gt_open = 1; temp_hot = 1; run(10);
    check(state_code == 3'd7, "R10", "flags ignored", state_code, 7);
    temp_hot = 0; v_gt_open = 0; dchg_latch = 0;
    wait_state(1, 3, "R10");
    // R2: supply loss in precharge
    cur_req = "R2"; insert_pack(); supply_ok = 0;
    wait_state(0, 8, "R2");
    supply_ok = 1; wait_state(1, 8, "R2");
    wait_state(2, 40, "R3");
    // R6/R7: zero limit expires on first tick
    cur_req = "R6"; fast_limit = 0; v_lt_lb = 0;
    wait_state(3, 4, "R6");
    wait_state(4, 6, "R6");
    cur_req = "R7"; wait_state(5, 6, "R7");
    // R10: latch ignored while in reset
    cur_req = "R10"; supply_ok = 0; wait_state(0, 8, "R2");
    dchg_latch = 1; run(2);
    check(state_code == 3'd0, "R10", "latch in reset", state_code, 0);
    supply_ok = 1; wait_state(7, 10, "R10");
    dchg_latch = 0; wait_state(1, 3, "R10");
    run(5);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule